// File: doc/BRIEF.md
# Resolution-Selectable Sinc2 Decimation Filter

This block turns a one-bit sigma-delta bitstream into a multi-bit conversion result. A three-bit resolution code picks an effective resolution from 6 to 13 bits. Two cascaded accumulators integrate the stream and wrap silently. At the end of every decimation window, one stored difference register forms the second-order difference. The accumulated window sum is also dumped at that point, which gives a sinc2 response.

To keep the output path cheap, the incoming bit is weighted before integration by a power of two that shrinks as the resolution grows. The final scaling is then one fixed round-and-shift for every code. Each new sample is held in a 32-bit result word, and a ready flag goes up with it. A read strobe clears the flag. Writing a different resolution code restarts the conversion from empty accumulators.

The result is not saturated: a stream of all ones reads as 2^enob and not 2^enob−1. After a step in the input, the second complete window gives a settled reading.

Top module: `sinc2_adc_filter`

## Requirements
- R1: While reset is low and on the first clock after it is released, `ready` is 0 and `result` is 0.
- R2: With the code held at c, a new result appears, and `ready` rises, once every 2^(5+c) clocks. The effective resolution is 6+c bits.
- R3: For an input that repeats with a period dividing 32 clocks, every result from the second one after reset or a code change equals 2^(6+c) × (fraction of ones in the stream).
- R4: An all-ones stream yields exactly 2^(6+c), for example 64 at code 0, 512 at code 3 and 8192 at code 7. No clamping is applied.
- R5: Bits 31 down to 15 of `result` are always 0; the sample sits in bits 14:0.
- R6: The first result after reset or after a code change, with an all-ones stream, equals 2^(5+c)−1. This holds because both accumulators start from zero and the second one adds the first one's value from before that clock's update.
- R7: `ready` stays 1 and `result` stays unchanged until either `rd_en` is sampled high, which clears `ready` on that edge, or a new result arrives.
- R8: A clock edge that sees `res_code` differ from the code in use clears `ready` and both accumulators. The first result at the new code then arrives 2^(5+c) clocks after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every bit of the stream is taken on a rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_in | input | 1 | Modulator bitstream |
| res_code | input | 3 | Resolution code c; effective bits = 6 + c |
| rd_en | input | 1 | Read strobe; clears `ready` |
| result | output | 32 | Latest conversion, zero-extended |
| ready | output | 1 | A result has arrived that has not yet been read |

## Verification
The hardest state to reach from the ports is the first window after a restart. There the stored difference is still zero, so the output exposes both the accumulator clearing and the order in which the two accumulators update. Mid-stream code switches reach this state, and so do reset releases under an all-ones stream. In both cases the first sample must land exactly one code below half scale, and an off-by-one in the update order shifts it by two. Steady-state values use periodic patterns whose period divides every window length. Each window then holds the same number of ones, so the exact value can be predicted for every code.

// File: rtl/sinc2_pkg.sv
// sinc2_pkg: default sizing shared by the filter, its submodules and its checker.
// Assumes a code range whose span (MAX - MIN) fills the code field exactly.
package sinc2_pkg;
    localparam int MIN_ENOB_D = 6;
    localparam int MAX_ENOB_D = 13;
    localparam int OUT_W_D    = 32;
endpackage

// File: rtl/s2_scaler.sv
// s2_scaler: weights the incoming bit by 2^(SPAN - code) so that all codes
// share one output shift. Assumes code <= SPAN.
module s2_scaler #(
    parameter int MIN_ENOB = sinc2_pkg::MIN_ENOB_D,
    parameter int MAX_ENOB = sinc2_pkg::MAX_ENOB_D,
    parameter int ACC_W    = 2 * MAX_ENOB - 1,
    parameter int CODE_W   = 3
) (
    input  logic              bit_in,
    input  logic [CODE_W-1:0] code,
    output logic [ACC_W-1:0]  step
);
    localparam int SPAN = MAX_ENOB - MIN_ENOB;

    logic [CODE_W-1:0] shamt;

    // Shift amount shrinks as resolution grows.
    always_comb begin
        shamt = CODE_W'(SPAN) - code;
        step  = bit_in ? (ACC_W'(1) << shamt) : '0;
    end
endmodule

// File: rtl/s2_integrators.sv
// s2_integrators: two cascaded accumulators that wrap modulo 2^ACC_W. The second
// adds the first's pre-update value; dump empties the second after its sum is taken.
module s2_integrators #(
    parameter int ACC_W = 25
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             dump,
    input  logic [ACC_W-1:0] step,
    output logic [ACC_W-1:0] win_sum
);
    logic [ACC_W-1:0] acc1;
    logic [ACC_W-1:0] acc2;

    // Sum presented to the difference stage on a dump clock.
    assign win_sum = acc2 + acc1;

    // Accumulator update with clear priority over dump.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            acc1 <= '0;
            acc2 <= '0;
        end else begin
            acc1 <= acc1 + step;
            acc2 <= dump ? '0 : win_sum;
        end
    end
endmodule

// File: rtl/s2_window.sv
// s2_window: counts the decimation window of 2^(MIN_ENOB-1+code) clocks and
// pulses dump on its last clock. Assumes the longest window fits in CNT_W bits.
module s2_window #(
    parameter int MIN_ENOB = sinc2_pkg::MIN_ENOB_D,
    parameter int CNT_W    = 12,
    parameter int CODE_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic [CODE_W-1:0] code,
    output logic              dump
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last;

    // Terminal count for the current code.
    always_comb begin
        last = CNT_W'((1 << (MIN_ENOB - 1 + int'(code))) - 1);
        dump = (cnt == last) && !clear;
    end

    // Window position, restarted by clear or at window end.
    always_ff @(posedge clk) begin
        if (!rst_n || clear || dump) cnt <= '0;
        else                         cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/s2_diff_out.sv
// s2_diff_out: forms the window-to-window difference, rounds it by a fixed
// shift, and holds the result with a ready flag. Assumes OUT_W >= sample width.
module s2_diff_out #(
    parameter int ACC_W    = 25,
    parameter int ROUND_SH = 11,
    parameter int OUT_W    = sinc2_pkg::OUT_W_D
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             dump,
    input  logic             rd_en,
    input  logic [ACC_W-1:0] win_sum,
    output logic [OUT_W-1:0] result,
    output logic             ready
);
    localparam int SAMP_W = ACC_W + 1 - ROUND_SH;

    logic [ACC_W-1:0]  diff_q;
    logic [ACC_W-1:0]  delta;
    logic [ACC_W:0]    biased;
    logic [SAMP_W-1:0] sample;

    // Wrapping difference, then add half an LSB and shift.
    always_comb begin
        delta  = win_sum - diff_q;
        biased = {1'b0, delta} + (ACC_W + 1)'(1 << (ROUND_SH - 1));
        sample = biased[ACC_W:ROUND_SH];
    end

    // Stored difference follows each window sum.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) diff_q <= '0;
        else if (dump)       diff_q <= win_sum;
    end

    // Result word held between windows.
    always_ff @(posedge clk) begin
        if (!rst_n)    result <= '0;
        else if (dump) result <= {{(OUT_W - SAMP_W){1'b0}}, sample};
    end

    // Ready: clear beats a new result, which beats a read.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) ready <= 1'b0;
        else if (dump)       ready <= 1'b1;
        else if (rd_en)      ready <= 1'b0;
    end
endmodule

// File: rtl/sinc2_adc_filter.sv
// sinc2_adc_filter: resolution-selectable sinc2 decimator for a one-bit stream.
// Assumes res_code is synchronous to clk; a changed code restarts the conversion.
module sinc2_adc_filter #(
    parameter int MIN_ENOB = sinc2_pkg::MIN_ENOB_D,
    parameter int MAX_ENOB = sinc2_pkg::MAX_ENOB_D,
    parameter int OUT_W    = sinc2_pkg::OUT_W_D
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_in,
    input  logic [2:0]       res_code,
    input  logic             rd_en,
    output logic [OUT_W-1:0] result,
    output logic             ready
);
    localparam int CODE_W   = 3;
    localparam int ACC_W    = 2 * MAX_ENOB - 1;
    localparam int CNT_W    = MAX_ENOB - 1;
    localparam int ROUND_SH = MAX_ENOB - 2;

    logic [CODE_W-1:0] code_q;
    logic              chg;
    logic              dump;
    logic [ACC_W-1:0]  step;
    logic [ACC_W-1:0]  win_sum;

    assign chg = (res_code != code_q);

    // Code in use; a difference triggers a one-clock restart.
    always_ff @(posedge clk) begin
        if (!rst_n) code_q <= '0;
        else        code_q <= res_code;
    end

    s2_scaler #(.MIN_ENOB(MIN_ENOB), .MAX_ENOB(MAX_ENOB), .ACC_W(ACC_W), .CODE_W(CODE_W)) u_scale (
        .bit_in(bit_in), .code(code_q), .step(step)
    );

    s2_window #(.MIN_ENOB(MIN_ENOB), .CNT_W(CNT_W), .CODE_W(CODE_W)) u_win (
        .clk(clk), .rst_n(rst_n), .clear(chg), .code(code_q), .dump(dump)
    );

    s2_integrators #(.ACC_W(ACC_W)) u_int (
        .clk(clk), .rst_n(rst_n), .clear(chg), .dump(dump), .step(step), .win_sum(win_sum)
    );

    s2_diff_out #(.ACC_W(ACC_W), .ROUND_SH(ROUND_SH), .OUT_W(OUT_W)) u_out (
        .clk(clk), .rst_n(rst_n), .clear(chg), .dump(dump), .rd_en(rd_en),
        .win_sum(win_sum), .result(result), .ready(ready)
    );
endmodule

// File: rtl/sinc2_adc_filter_chk.sv
// sinc2_adc_filter_chk: temporal checks on the filter's ports and window control.
module sinc2_adc_filter_chk #(
    parameter int MIN_ENOB = 6,
    parameter int OUT_W    = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       res_code,
    input logic             rd_en,
    input logic [OUT_W-1:0] result,
    input logic             ready,
    input logic [2:0]       code_q,
    input logic             dump
);
    logic        rst_q = 1'b1;
    logic [15:0] gap;

    // Previous reset level.
    always @(posedge clk) rst_q <= rst_n;

    // Clocks since the window started.
    always @(posedge clk) begin
        if (!rst_n || res_code != code_q || dump) gap <= '0;
        else                                      gap <= gap + 1'b1;
    end

    a_r1_reset_idle: assert property (@(posedge clk)
        (rst_n && !rst_q) |-> (!ready && result == '0));

    a_r2_period: assert property (@(posedge clk) disable iff (!rst_n)
        dump |-> (gap == 16'((1 << (MIN_ENOB - 1 + int'(code_q))) - 1)));

    a_r2_ready_on_dump: assert property (@(posedge clk) disable iff (!rst_n)
        dump |=> ready);

    a_r7_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !dump |=> $stable(result));

    a_r5_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        result[OUT_W-1:15] == '0);

    a_r7_hold_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !rd_en && res_code == code_q) |=> ready);

    a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !dump) |=> !ready);

    a_r8_change_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (res_code != code_q) |=> !ready);
endmodule

bind sinc2_adc_filter sinc2_adc_filter_chk #(.MIN_ENOB(MIN_ENOB), .OUT_W(OUT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .res_code(res_code), .rd_en(rd_en),
    .result(result), .ready(ready), .code_q(code_q), .dump(dump)
);

// File: tb/tb_sinc2_adc_filter.sv
// tb_sinc2_adc_filter: table-driven steady-state checks plus directed restart,
// read-handshake and reset tests.
module tb_sinc2_adc_filter;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 10;

    typedef struct packed {
        logic [2:0]  code;
        logic [31:0] pat;
        logic [31:0] exp;
    } vec_t;

    // Expected value = 2^(6+code) * ones/32 = ones * 2^(1+code).
    localparam vec_t VECS [NVEC] = '{
        '{3'd0, 32'h0000_0000, 32'd0},
        '{3'd0, 32'hFFFF_FFFF, 32'd64},
        '{3'd0, 32'hAAAA_AAAA, 32'd32},
        '{3'd1, 32'h1111_1111, 32'd32},
        '{3'd2, 32'h7777_7777, 32'd192},
        '{3'd3, 32'h0000_FFFF, 32'd256},
        '{3'd4, 32'h0000_0001, 32'd32},
        '{3'd5, 32'hFFFF_FFFE, 32'd1984},
        '{3'd6, 32'h3333_3333, 32'd2048},
        '{3'd7, 32'hFFFF_FFFF, 32'd8192}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_in = 1'b0;
    logic [2:0]  res_code = 3'd0;
    logic        rd_en = 1'b0;
    logic [31:0] result;
    logic        ready;

    logic [31:0] pat = 32'hFFFF_FFFF;
    logic [4:0]  phase = '0;
    int          cyc = 0;
    int          n_chk = 0;
    int          n_bad = 0;

    sinc2_adc_filter dut (
        .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .res_code(res_code),
        .rd_en(rd_en), .result(result), .ready(ready)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Stream driver: repeats the 32-bit pattern, one bit per clock.
    always @(negedge clk) begin
        bit_in <= pat[phase];
        phase  <= phase + 1'b1;
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic get_result(input bit do_read, output logic [31:0] v, output int at);
        do @(negedge clk); while (!ready);
        v  = result;
        at = cyc;
        if (do_read) begin
            rd_en = 1'b1;
            @(negedge clk);
            rd_en = 1'b0;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got %0d expected %0d", cyc, 0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [31:0] held;
        int t0, t1, c0;

        // R1: reset state.
        repeat (3) @(negedge clk);
        check(ready == 1'b0, "R1 ready in reset", ready, 0);
        check(result == 32'd0, "R1 result in reset", result, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(ready == 1'b0 && result == 32'd0, "R1 after release", result, 0);

        // R6: first window after reset, all ones, code 0.
        get_result(1, v, t0);
        check(v == 32'd31, "R6 first after reset", v, 31);
        get_result(1, v, t1);
        check(v == 32'd64, "R4 all ones code 0", v, 64);
        check(t1 - t0 == 32, "R2 period code 0", t1 - t0, 32);
        check(v[31:15] == '0, "R5 upper bits", v[31:15], 0);

        // R7: unread result is held, read clears.
        get_result(0, held, t0);
        repeat (5) @(negedge clk);
        check(ready == 1'b1, "R7 ready held", ready, 1);
        check(result == held, "R7 result held", result, held);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        check(ready == 1'b0, "R7 read clears", ready, 0);

        // R8: code change with a pending result.
        get_result(0, v, t0);
        res_code = 3'd3;
        c0 = cyc;
        @(negedge clk);
        check(ready == 1'b0, "R8 change clears ready", ready, 0);
        get_result(1, v, t0);
        check(t0 - c0 == 257, "R8 restart timing", t0 - c0, 257);
        check(v == 32'd255, "R6 first after change", v, 255);
        get_result(1, v, t1);
        check(v == 32'd512, "R4 all ones code 3", v, 512);
        check(t1 - t0 == 256, "R2 period code 3", t1 - t0, 256);

        // R3: table of patterns across codes.
        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            rst_n = 1'b0;
            res_code = VECS[i].code;
            pat = VECS[i].pat;
            repeat (2) @(negedge clk);
            rst_n = 1'b1;
            get_result(1, v, t0);
            get_result(1, v, t0);
            check(v == VECS[i].exp, $sformatf("R3 vec %0d second", i), v, VECS[i].exp);
            get_result(1, v, t1);
            check(v == VECS[i].exp, $sformatf("R3 vec %0d third", i), v, VECS[i].exp);
            check(t1 - t0 == (1 << (5 + int'(VECS[i].code))), $sformatf("R2 vec %0d period", i),
                  t1 - t0, 1 << (5 + int'(VECS[i].code)));
            check(v[31:15] == '0, $sformatf("R5 vec %0d upper", i), v[31:15], 0);
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule